// File: doc/BRIEF.md
# DMA Host Burst Address Generator

This block is the command engine for one memory-mapped host port of a descriptor-driven DMA engine. It takes one descriptor at a time: a byte start address, a byte length, a stride in words, a burst-enable bit and a forced-alignment bit. From these it produces a series of memory-mapped commands. Each command carries an address, a burst count and byte enables. It keeps track of how many bytes are left and how many issued writes still wait for their response. It raises a one-cycle completion pulse once the whole transfer has been issued and, when write-response tracking is built in, every write has been acknowledged.

Bursts are sized from the whole words that remain. A trailing partial word always goes out as its own single-beat command with a reduced byte-enable mask. In stride mode the address jumps by stride words per beat. With forced alignment, single beats are sent until the address reaches a burst boundary. A descriptor that breaks the mode rules is refused: it gives an error pulse together with done and issues no command.

Top module: `dma_burst_addr_gen`

## Requirements
- R1: `desc_ready` is high exactly when the block is idle, and a descriptor is taken on a cycle with `desc_valid` and `desc_ready` both high. `busy` is high from the cycle after acceptance through the cycle in which `done` is high. `done` lasts one cycle, after which the block is idle. A descriptor offered while busy is ignored. After reset the block is idle with no command and no done.
- R2: The stride field counts words, and a value of 0 or 1 means sequential addressing. In stride mode every command has a burst count of 1, and the address grows by stride × (DATA_W/8) bytes per accepted command.
- R3: A descriptor with burst enable set and a stride of 2 or more issues no command. It produces `done` with `err` high in the cycle after acceptance.
- R4: A start address whose low log2(DATA_W/8) bits are not zero is refused in the same way as R3. With FULL_WORD=1, a length that is not a multiple of DATA_W/8 is refused too. With FULL_WORD=0, any length is accepted.
- R5: With burst enable set, each command's burst count is the smaller of MAX_BURST and the whole words remaining. With burst enable clear, every command has a burst count of 1. The address advances by burst × DATA_W/8 bytes.
- R6: With forced alignment set, a command whose address is not a multiple of MAX_BURST × DATA_W/8 has a burst count of 1. Once that boundary is reached, full bursts follow.
- R7: Byte-enable bit i covers byte i of the word. Commands made of whole words have every bit set. When fewer than DATA_W/8 bytes remain, they go out in one single-beat command whose byte enables are set only on the lowest (remaining) bits.
- R8: With NO_BYTEEN=1, every command has all byte enables set, including the trailing partial word.
- R9: While `cmd_valid` and `cmd_wait` are both high, the command's address, burst count and byte enables hold steady, and so does `cmd_valid`. Progress is made only on a cycle with `cmd_valid` high and `cmd_wait` low.
- R10: With WRITE_RESP=1, each accepted command adds one outstanding write and each `wr_resp` pulse removes one. `done` is raised only after every issued write has been answered.
- R11: A zero-length descriptor issues no command. It produces `done` with `err` low in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Byte start address |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_stride | input | STRIDE_W | Stride in words (0 or 1 means sequential) |
| desc_burst | input | 1 | Burst enable |
| desc_align | input | 1 | Forced burst alignment |
| cmd_valid | output | 1 | Command presented |
| cmd_wait | input | 1 | Target stall; command must be held |
| cmd_addr | output | ADDR_W | Command byte address |
| cmd_burst | output | $clog2(MAX_BURST+1) | Beats in this command |
| cmd_byteen | output | DATA_W/8 | Byte enables of the command's beats |
| wr_resp | input | 1 | One write response |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Descriptor refused, valid with done |

## Verification
The command stream is compared, one item at a time, against sequences worked out from the rules. The patterns are: sequential single beats, bursts with a short final burst, a partial tail word, several strides, and one misaligned start run both with and without forced alignment. That last pair separates correct boundary fill-in from plain bursting. Random target stalls show whether commands hold steady and whether the address and the remaining length move only on accepted cycles. Responses delayed by several cycles show whether done waits for the last acknowledgement. Refused descriptors, zero length and extra instances with the full-word and no-byte-enable options cover the cases that end immediately or change masks.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } ag_state_e;
endpackage

// File: rtl/dma_ag_beat_calc.sv
// Combinational sizing of the next command from the registered cursor.
module dma_ag_beat_calc #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BYTES     = 4,
  parameter int MAX_BURST = 4,
  parameter int STRIDE_W  = 8,
  parameter int NO_BYTEEN = 0,
  localparam int LOG_B    = $clog2(BYTES),
  localparam int LOG_MB   = $clog2(MAX_BURST),
  localparam int BC_W     = $clog2(MAX_BURST + 1)
) (
  input  logic [LOG_MB-1:0]   addr_in_burst,
  input  logic [LEN_W-1:0]    rem_len,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                burst_on,
  input  logic                align_on,
  output logic [BC_W-1:0]     burst_cnt,
  output logic [BYTES-1:0]    byte_en,
  output logic [ADDR_W-1:0]   addr_step,
  output logic [LEN_W-1:0]    len_used
);

  // Low n bytes enabled.
  function automatic logic [BYTES-1:0] tail_mask(input logic [LOG_B-1:0] n);
    logic [BYTES-1:0] m;
    for (int i = 0; i < BYTES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // Beats for a command made of whole words.
  function automatic logic [BC_W-1:0] pick_burst(input logic [LEN_W-1:0] words,
                                                 input logic on, input logic hold_single);
    if (!on || hold_single)            return BC_W'(1);
    else if (words >= LEN_W'(MAX_BURST)) return BC_W'(MAX_BURST);
    else                               return words[BC_W-1:0];
  endfunction

  logic [LEN_W-1:0] whole_words;
  logic [LOG_B-1:0] tail_bytes;
  logic             off_boundary;

  assign whole_words  = rem_len >> LOG_B;
  assign tail_bytes   = rem_len[LOG_B-1:0];
  assign off_boundary = align_on && (addr_in_burst != '0);

  always_comb begin
    if (whole_words == '0) begin
      burst_cnt = BC_W'(1);
      byte_en   = (NO_BYTEEN != 0) ? '1 : tail_mask(tail_bytes);
      len_used  = rem_len;
    end else begin
      burst_cnt = pick_burst(whole_words, burst_on, off_boundary);
      byte_en   = '1;
      len_used  = LEN_W'(burst_cnt) << LOG_B;
    end
    addr_step = (ADDR_W'(burst_cnt) * ADDR_W'(stride)) << LOG_B;
  end

endmodule

// File: rtl/dma_ag_pending.sv
// Outstanding write counter.
module dma_ag_pending #(
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic is_zero,
  output logic is_full
);

  logic [CNT_W-1:0] cnt;
  logic             dec_ok;

  assign dec_ok  = dec && ((cnt != '0) || inc);
  assign is_zero = (cnt == '0);
  assign is_full = (cnt == CNT_W'(MAX_OUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CNT_W'(inc) - CNT_W'(dec_ok);
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_full |-> !inc) else $error("R10: outstanding counter overflow");

  p_step_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> !is_zero) else $error("R10: count lost on issue");

endmodule

// File: rtl/dma_burst_addr_gen.sv
module dma_burst_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_W     = 32,
  parameter int MAX_BURST  = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int STRIDE_W   = 8,
  parameter int MAX_OUT    = 16,
  parameter int FULL_WORD  = 0,
  parameter int NO_BYTEEN  = 0,
  parameter int WRITE_RESP = 1,
  localparam int BYTES     = DATA_W / 8,
  localparam int LOG_B     = $clog2(BYTES),
  localparam int LOG_MB    = $clog2(MAX_BURST),
  localparam int BC_W      = $clog2(MAX_BURST + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_valid,
  output logic                desc_ready,
  input  logic [ADDR_W-1:0]   desc_addr,
  input  logic [LEN_W-1:0]    desc_len,
  input  logic [STRIDE_W-1:0] desc_stride,
  input  logic                desc_burst,
  input  logic                desc_align,
  output logic                cmd_valid,
  input  logic                cmd_wait,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [BC_W-1:0]     cmd_burst,
  output logic [BYTES-1:0]    cmd_byteen,
  input  logic                wr_resp,
  output logic                busy,
  output logic                done,
  output logic                err
);
  import dma_ag_pkg::*;

  // Parameter rules checked at elaboration.
  if (MAX_BURST * 4 > FIFO_DEPTH) begin : g_bad_fifo
    $error("MAX_BURST exceeds a quarter of FIFO_DEPTH");
  end
  if (BYTES < 2 || (1 << LOG_B) != BYTES) begin : g_bad_width
    $error("DATA_W must give a power-of-two byte count of at least 2");
  end
  if (MAX_BURST < 2 || (1 << LOG_MB) != MAX_BURST) begin : g_bad_burst
    $error("MAX_BURST must be a power of two of at least 2");
  end

  ag_state_e           state;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    rem_q;
  logic [STRIDE_W-1:0] stride_q;
  logic                burst_q, align_q, err_q;

  // Named events for the assertions.
  logic                desc_take, cmd_take, last_take, bad_desc;
  logic                pend_zero, pend_full;
  logic [STRIDE_W-1:0] stride_in;
  logic [ADDR_W-1:0]   addr_step;
  logic [LEN_W-1:0]    len_used, rem_next;

  assign stride_in  = (desc_stride == '0) ? STRIDE_W'(1) : desc_stride;
  assign bad_desc   = (desc_burst && stride_in > STRIDE_W'(1))
                    || (desc_addr[LOG_B-1:0] != '0)
                    || ((FULL_WORD != 0) && (desc_len[LOG_B-1:0] != '0));

  assign desc_ready = (state == ST_IDLE);
  assign desc_take  = desc_valid && desc_ready;
  assign cmd_valid  = (state == ST_RUN) && !pend_full;
  assign cmd_take   = cmd_valid && !cmd_wait;
  assign rem_next   = rem_q - len_used;
  assign last_take  = cmd_take && (rem_next == '0);
  assign cmd_addr   = addr_q;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
  assign err        = done && err_q;

  dma_ag_beat_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BYTES), .MAX_BURST(MAX_BURST),
    .STRIDE_W(STRIDE_W), .NO_BYTEEN(NO_BYTEEN)
  ) u_calc (
    .addr_in_burst(addr_q[LOG_B +: LOG_MB]),
    .rem_len(rem_q),
    .stride(stride_q),
    .burst_on(burst_q),
    .align_on(align_q),
    .burst_cnt(cmd_burst),
    .byte_en(cmd_byteen),
    .addr_step(addr_step),
    .len_used(len_used)
  );

  dma_ag_pending #(.MAX_OUT(MAX_OUT)) u_pend (
    .clk(clk),
    .rst_n(rst_n),
    .inc(cmd_take && (WRITE_RESP != 0)),
    .dec(wr_resp && (WRITE_RESP != 0)),
    .is_zero(pend_zero),
    .is_full(pend_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      stride_q <= STRIDE_W'(1);
      burst_q  <= 1'b0;
      align_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (desc_take) begin
          addr_q   <= desc_addr;
          rem_q    <= desc_len;
          stride_q <= stride_in;
          burst_q  <= desc_burst;
          align_q  <= desc_align;
          err_q    <= bad_desc;
          if (bad_desc || desc_len == '0) state <= ST_FIN;
          else                            state <= ST_RUN;
        end
        ST_RUN: if (cmd_take) begin
          addr_q <= addr_q + addr_step;
          rem_q  <= rem_next;
          if (rem_next == '0) state <= (WRITE_RESP != 0) ? ST_DRAIN : ST_FIN;
        end
        ST_DRAIN: if (pend_zero) state <= ST_FIN;
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !busy) else $error("R1: ready while busy");

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)) else $error("R1: done longer than one cycle");

  p_stride_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && stride_q > STRIDE_W'(1)) |-> cmd_burst == BC_W'(1))
    else $error("R2: burst in stride mode");

  p_err_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done) else $error("R3: error without done");

  p_burst_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_burst != '0 && cmd_burst <= BC_W'(MAX_BURST)))
    else $error("R5: burst count out of range");

  p_tail_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byteen != '1) |-> cmd_burst == BC_W'(1))
    else $error("R7: partial mask on a burst");

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_wait) |=> (cmd_valid && $stable(cmd_addr)
                                 && $stable(cmd_burst) && $stable(cmd_byteen)))
    else $error("R9: command changed under stall");

  p_last_then_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !cmd_valid) else $error("R10: command after the last one");

  p_done_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend_zero) else $error("R10: done with writes outstanding");

endmodule

// File: tb/tb_dma_burst_addr_gen.sv
module tb_dma_burst_addr_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0, desc_burst = 1'b0, desc_align = 1'b0;
  logic [31:0] desc_addr = '0;
  logic [15:0] desc_len = '0;
  logic [7:0]  desc_stride = 8'd1;
  logic        cmd_wait = 1'b0, wr_resp = 1'b0;
  logic        desc_ready, cmd_valid, busy, done, err;
  logic [31:0] cmd_addr;
  logic [2:0]  cmd_burst;
  logic [3:0]  cmd_byteen;

  dma_burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_len(desc_len), .desc_stride(desc_stride),
    .desc_burst(desc_burst), .desc_align(desc_align), .cmd_valid(cmd_valid),
    .cmd_wait(cmd_wait), .cmd_addr(cmd_addr), .cmd_burst(cmd_burst),
    .cmd_byteen(cmd_byteen), .wr_resp(wr_resp), .busy(busy), .done(done), .err(err)
  );

  // Side instances for the build-time options.
  logic        s_valid = 1'b0;
  logic [15:0] s_len = '0;
  logic        nb_ready, nb_valid, nb_busy, nb_done, nb_err;
  logic [31:0] nb_addr;
  logic [2:0]  nb_burst;
  logic [3:0]  nb_be;
  logic        fw_ready, fw_valid, fw_busy, fw_done, fw_err;
  logic [31:0] fw_addr;
  logic [2:0]  fw_burst;
  logic [3:0]  fw_be;

  dma_burst_addr_gen #(.NO_BYTEEN(1), .WRITE_RESP(0)) dut_nb (
    .clk(clk), .rst_n(rst_n), .desc_valid(s_valid), .desc_ready(nb_ready),
    .desc_addr(32'h40), .desc_len(s_len), .desc_stride(8'd1),
    .desc_burst(1'b0), .desc_align(1'b0), .cmd_valid(nb_valid),
    .cmd_wait(1'b0), .cmd_addr(nb_addr), .cmd_burst(nb_burst),
    .cmd_byteen(nb_be), .wr_resp(1'b0), .busy(nb_busy), .done(nb_done), .err(nb_err)
  );

  dma_burst_addr_gen #(.FULL_WORD(1), .WRITE_RESP(0)) dut_fw (
    .clk(clk), .rst_n(rst_n), .desc_valid(s_valid), .desc_ready(fw_ready),
    .desc_addr(32'h40), .desc_len(s_len), .desc_stride(8'd1),
    .desc_burst(1'b0), .desc_align(1'b0), .cmd_valid(fw_valid),
    .cmd_wait(1'b0), .cmd_addr(fw_addr), .cmd_burst(fw_burst),
    .cmd_byteen(fw_be), .wr_resp(1'b0), .busy(fw_busy), .done(fw_done), .err(fw_err)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [2:0]  b;
    logic [3:0]  be;
  } exp_t;

  exp_t  q[$];
  exp_t  prev_cmd;
  bit    prev_wait = 1'b0;
  bit    wait_mode = 1'b0;
  int    checks = 0, errors = 0, pending = 0, tick = 0;
  string cur = "R1 idle";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected command list, from the requirements.
  task automatic build(input logic [31:0] addr, input int len, input int stride,
                       input bit burst, input bit align);
    logic [31:0] a = addr;
    int r = len;
    int se = (stride == 0) ? 1 : stride;
    while (r > 0) begin
      int fw;
      int b;
      exp_t e;
      fw = r / 4;
      if (fw == 0) begin
        e = '{a, 3'd1, 4'((1 << r) - 1)};
        r = 0;
      end else begin
        b = 1;
        if (burst && !(align && (a % 16) != 0)) b = (fw < 4) ? fw : 4;
        e = '{a, 3'(b), 4'hF};
        a = a + 32'(b * 4 * se);
        r = r - b * 4;
      end
      q.push_back(e);
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t act;
      act = '{cmd_addr, cmd_burst, cmd_byteen};
      if (prev_wait)
        chk(cmd_valid && act == prev_cmd, "R9 hold under stall", longint'(act), longint'(prev_cmd));
      prev_wait = cmd_valid && cmd_wait;
      prev_cmd  = act;
      if (cmd_valid && !cmd_wait) begin
        pending++;
        if (q.size() == 0) chk(1'b0, {cur, " unexpected command"}, longint'(act), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(act == e, cur, longint'(act), longint'(e));
        end
      end
      if (busy && desc_ready) chk(1'b0, "R1 ready while busy", 1, 0);
      if (done && pending != 0) chk(1'b0, "R10 done before responses", pending, 0);
    end
  end

  // Delayed write responses.
  initial forever begin
    @(posedge clk); #1;
    if (pending > 0 && (tick % 3) == 2) begin
      wr_resp = 1'b1;
      pending--;
    end else wr_resp = 1'b0;
    tick++;
  end

  // Target stalls.
  initial forever begin
    @(posedge clk); #1;
    cmd_wait = wait_mode && (($urandom % 3) == 0);
  end

  task automatic run_desc(input logic [31:0] addr, input int len, input int stride,
                          input bit burst, input bit align, input bit exp_err,
                          input string tag);
    int cyc;
    cur = tag;
    if (!exp_err) build(addr, len, stride, burst, align);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
    desc_addr = addr; desc_len = 16'(len); desc_stride = 8'(stride);
    desc_burst = burst; desc_align = align; desc_valid = 1'b1;
    @(posedge clk); #1;
    desc_valid = 1'b0;
    @(negedge clk);
    cyc = 1;
    chk(busy, {tag, " R1 busy after accept"}, busy, 1);
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, {tag, " done"}, done, 1);
    chk(err == exp_err, {tag, " err"}, err, exp_err);
    chk(q.size() == 0, {tag, " all commands issued"}, q.size(), 0);
    chk(pending == 0, {tag, " R10 all writes answered"}, pending, 0);
    if (len == 0 || exp_err) chk(cyc == 1, {tag, " immediate done"}, cyc, 1);
    @(negedge clk);
    chk(!done && !busy && desc_ready, "R1 done lasts one cycle", {done, busy}, 0);
    q.delete();
  endtask

  task automatic side_run(input int len);
    int ncmd = 0;
    bit allf = 1'b1, fwdone = 1'b0, fwerr = 1'b0;
    @(posedge clk); #1;
    s_len = 16'(len); s_valid = 1'b1;
    @(posedge clk); #1;
    s_valid = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (nb_valid) begin
        ncmd++;
        if (nb_be != 4'hF) allf = 1'b0;
      end
      if (fw_done) begin
        fwdone = 1'b1;
        fwerr = fw_err;
      end
    end
    chk(ncmd == (len + 3) / 4, "R8 beat count", ncmd, (len + 3) / 4);
    chk(allf, "R8 byte enables held high", allf, 1);
    chk(fwdone && fwerr == ((len % 4) != 0), "R4 full-word length rule",
        {fwdone, fwerr}, {1'b1, (len % 4) != 0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_ready && !busy && !done && !cmd_valid, "R1 reset state",
        {desc_ready, busy, done, cmd_valid}, 4'b1000);

    run_desc(32'h100, 12, 1, 0, 0, 0, "R5 single beats, burst off");
    run_desc(32'h200, 40, 1, 1, 0, 0, "R5 bursts with short last");
    run_desc(32'h108, 48, 1, 1, 1, 0, "R6 forced alignment fill-in");
    run_desc(32'h108, 48, 1, 1, 0, 0, "R6 same start, alignment off");
    run_desc(32'h300, 10, 1, 1, 0, 0, "R7 partial tail word");
    run_desc(32'h303 & 32'hFFFC, 3, 1, 0, 0, 0, "R7 tail-only transfer");
    run_desc(32'h400, 9, 3, 0, 0, 0, "R2 stride three");
    run_desc(32'h500, 8, 0, 0, 0, 0, "R2 stride zero sequential");
    run_desc(32'h600, 16, 2, 1, 0, 1, "R3 burst with stride refused");
    run_desc(32'h102, 16, 1, 0, 0, 1, "R4 misaligned address refused");
    run_desc(32'h700, 0, 1, 1, 0, 0, "R11 zero length");

    wait_mode = 1'b1;
    run_desc(32'h1004, 64, 1, 1, 1, 0, "R9 stalls with aligned bursts");
    fork
      run_desc(32'h2000, 80, 1, 0, 0, 0, "R1 descriptor ignored while busy");
      begin
        repeat (4) @(posedge clk);
        #2;
        desc_addr = 32'h9000; desc_len = 16'd4; desc_valid = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        desc_valid = 1'b0;
      end
    join
    wait_mode = 1'b0;

    side_run(6);
    side_run(8);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule